// File: doc/BRIEF.md
# Chained Command Descriptor Sequencer

This block is the control engine of a single DMA channel. It walks a linked list of command descriptors that sit in memory. Software loads the address of the first descriptor and then writes a count into a semaphore counter. While the counter is nonzero and the channel is armed, the sequencer fetches one descriptor at a time through a plain request/acknowledge read port. It decodes the command half-word and forwards any inline register words to a peripheral register port. It then hands a read, write or no-transfer operation to an external data mover. When the descriptor completes, the sequencer may pulse a completion output and decrement the semaphore. It then follows the chain pointer.

A descriptor is a run of 32-bit words at byte addresses base, base+4 and so on. Word 0 is the pointer to the next descriptor. The low half of word 1 is the command half-word and the high half is the byte count. Word 2 is the buffer address. The inline register words, if any, follow from word 3. A chain whose last pointer leads back to an earlier descriptor forms a ring. The ring keeps running until enough semaphore decrements bring the counter to zero, and a later semaphore write resumes it where it stopped.

Top module: `cmd_chain_seq`

## Requirements
- R1: After reset `busy`, `halted`, `mem_req`, `irq_pulse`, `err_pulse` and `sema_level` are all 0.
- R2: A `sema_we` write adds `sema_val` to the semaphore and arms the channel. An armed channel with a nonzero semaphore fetches from the address last loaded through `start_addr_we`. Nothing is fetched while the semaphore is zero.
- R3: Descriptor layout: word 0 is the next pointer, word 1 bits 15:0 are the command and bits 31:16 the byte count, word 2 is the buffer address. Command bits 15:12 give the number of inline register words (0 to 15), which start at word 3. A byte count of 0xFF00 is accepted.
- R4: Inline register words are sent on `pio_we`/`pio_idx`/`pio_data` in memory order, with indexes 0, 1, 2 and so on, before the data phase starts.
- R5: Command bits 1:0 select the operation: 0 runs no data phase, 1 (write to memory) and 2 (read from memory) pulse `xfer_start` once, with `xfer_op` equal to the code, `xfer_addr` equal to the buffer word and `xfer_len` equal to the byte count.
- R6: With command bit 2 set, the sequencer continues at the next pointer. With it clear, the sequencer disarms and goes idle after this descriptor. A later `sema_we` alone resumes at the pointer that was followed last.
- R7: With command bit 6 set, the semaphore drops by one when the descriptor completes. A ring stops, idle, when the semaphore reaches zero.
- R8: With command bit 3 set, `irq_pulse` is high for exactly one cycle when the descriptor completes. Otherwise no pulse is given.
- R9: With command bit 7 set, completion (pulse and decrement) waits after the data phase until `periph_end` is seen.
- R10: While `freeze` is high no new memory request and no new data phase starts. Work resumes when `freeze` is released.
- R11: A data-mover error, operation code 3, or a byte count above 0xFF00 on a transferring command gives one `err_pulse` and halts the channel (`halted`=1). No `irq_pulse` and no semaphore decrement follow.
- R12: `chan_reset` aborts any activity. The channel returns to idle, not halted and disarmed, and the semaphore is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Synchronous channel abort |
| freeze | input | 1 | Pause the channel while high |
| start_addr_we | input | 1 | Load first-descriptor address (idle only) |
| start_addr | input | AW | First-descriptor byte address |
| sema_we | input | 1 | Add to semaphore and arm |
| sema_val | input | SEMW | Value added to semaphore |
| sema_level | output | SEMW | Current semaphore count |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | AW | Byte address of requested word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pio_we | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Peripheral register index |
| pio_data | output | 32 | Peripheral register data |
| xfer_start | output | 1 | Data-phase start pulse |
| xfer_op | output | 2 | Operation code (1 write to memory, 2 read from memory) |
| xfer_addr | output | AW | Buffer address |
| xfer_len | output | 16 | Byte count |
| xfer_done | input | 1 | Data phase finished |
| xfer_err | input | 1 | Data phase failed (qualified by xfer_done) |
| periph_end | input | 1 | Peripheral end indication |
| irq_pulse | output | 1 | Completion pulse |
| err_pulse | output | 1 | Error pulse |
| busy | output | 1 | Channel has work in hand or ready to start |
| halted | output | 1 | Channel stopped on an error |

## Verification
On every cycle the assertions check the following. Freeze never lets a new memory request appear. A halted channel stays halted, issues nothing and does not leave its state without a reset. Each completion pulse lasts one cycle. An inline register index stays below the decoded word count. A data phase never overlaps a descriptor read and never carries more than the byte limit. A decrement lowers the semaphore by exactly one, and a reset leaves the channel idle and empty. Only the bench scenarios can show the end-to-end behaviour: the descriptor layout and the order and content of register writes for every word count, the chain walk, a ring stopping at zero and resuming, holding for the peripheral end, and each way into the error halt.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_XSTART,
      S_XWAIT,
      S_EWAIT,
      S_DONE,
      S_HALT
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_TOMEM   = 2'd1,
      OP_FROMMEM = 2'd2,
      OP_BAD     = 2'd3
   } op_t;

   // bit positions inside the 16-bit command half-word
   localparam int CB_CHAIN   = 2;
   localparam int CB_IRQ     = 3;
   localparam int CB_DEC     = 6;
   localparam int CB_WEND    = 7;
   localparam int CB_NPIO_LO = 12;

   typedef struct packed {
      op_t        op;
      logic       chain;
      logic       irq;
      logic       dec;
      logic       wend;
      logic [3:0] npio;
   } cmd_t;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
   import cmdseq_pkg::*;
#(
   parameter int MAX_LEN = 16'hFF00
) (
   input  logic [15:0] cmd_word,
   input  logic [15:0] len,
   output cmd_t        cmd,
   output logic        bad
);
   always_comb begin
      cmd.op    = op_t'(cmd_word[1:0]);
      cmd.chain = cmd_word[CB_CHAIN];
      cmd.irq   = cmd_word[CB_IRQ];
      cmd.dec   = cmd_word[CB_DEC];
      cmd.wend  = cmd_word[CB_WEND];
      cmd.npio  = cmd_word[CB_NPIO_LO +: 4];
      bad = (cmd.op == OP_BAD) ||
            ((cmd.op != OP_NONE) && (32'(len) > 32'(MAX_LEN)));
   end
endmodule

// File: rtl/cmdseq_sema.sv
module cmdseq_sema #(
   parameter int W   = 8,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add_en,
   input  logic [W-1:0] add_val,
   input  logic         dec_en,
   output logic [W-1:0] level
);
   logic [W:0]   wide, after;
   logic         take;
   logic [W-1:0] nxt;

   always_comb begin
      wide  = {1'b0, level} + (add_en ? {1'b0, add_val} : '0);
      take  = dec_en && (wide != '0);
      after = wide - (W+1)'(take);
   end

   generate
      if (SAT) begin : g_sat
         assign nxt = after[W] ? '1 : after[W-1:0];
      end else begin : g_wrap
         assign nxt = after[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   level <= '0;
      else if (clr) level <= '0;
      else          level <= nxt;
   end

   // R7: one decrement lowers the count by exactly one
   a_r7_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !add_en && !clr && level != '0) |=> (level == $past(level) - 1'b1));

   // R12: a clear empties the counter
   a_r12_clr_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
endmodule

// File: rtl/cmd_chain_seq.sv
module cmd_chain_seq
   import cmdseq_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SEMW     = 8,
   parameter int MAX_LEN  = 16'hFF00,
   parameter bit SEMA_SAT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            chan_reset,
   input  logic            freeze,
   input  logic            start_addr_we,
   input  logic [AW-1:0]   start_addr,
   input  logic            sema_we,
   input  logic [SEMW-1:0] sema_val,
   output logic [SEMW-1:0] sema_level,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_ack,
   input  logic [31:0]     mem_rdata,
   output logic            pio_we,
   output logic [3:0]      pio_idx,
   output logic [31:0]     pio_data,
   output logic            xfer_start,
   output logic [1:0]      xfer_op,
   output logic [AW-1:0]   xfer_addr,
   output logic [15:0]     xfer_len,
   input  logic            xfer_done,
   input  logic            xfer_err,
   input  logic            periph_end,
   output logic            irq_pulse,
   output logic            err_pulse,
   output logic            busy,
   output logic            halted
);
   localparam int IDXW  = 5;   // word index 0 .. 2+15
   localparam int FIXED = 3;   // words before inline register words

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("AW must be within 8..32");
      end
      if (SEMW < 1) begin : g_bad_semw
         $error("SEMW must be at least 1");
      end
      if (MAX_LEN < 1 || MAX_LEN > 65535) begin : g_bad_len
         $error("MAX_LEN must fit the 16-bit byte count");
      end
   endgenerate

   seq_state_t      state;
   logic [AW-1:0]   cur_addr, next_ptr, buf_r;
   logic [IDXW-1:0] word_idx, pio_off;
   logic [15:0]     cmd_raw, len_r;
   logic            req_r, armed;
   logic            pio_we_r, irq_r, err_r;
   logic [3:0]      pio_idx_r;
   logic [31:0]     pio_data_r;
   cmd_t            cmd;
   logic            cmd_bad, last_word, dec_en, run_ok;

   cmdseq_decode #(.MAX_LEN(MAX_LEN)) u_dec (
      .cmd_word(cmd_raw), .len(len_r), .cmd(cmd), .bad(cmd_bad)
   );

   cmdseq_sema #(.W(SEMW), .SAT(SEMA_SAT)) u_sema (
      .clk(clk), .rst_n(rst_n), .clr(chan_reset),
      .add_en(sema_we && !chan_reset), .add_val(sema_val),
      .dec_en(dec_en), .level(sema_level)
   );

   always_comb begin
      pio_off   = word_idx - IDXW'(FIXED);
      last_word = (word_idx == (IDXW'(cmd.npio) + IDXW'(FIXED - 1)));
      dec_en    = (state == S_DONE) && cmd.dec && !chan_reset;
      run_ok    = armed && (sema_level != '0) && !freeze;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cur_addr   <= '0;
         next_ptr   <= '0;
         buf_r      <= '0;
         word_idx   <= '0;
         cmd_raw    <= '0;
         len_r      <= '0;
         req_r      <= 1'b0;
         armed      <= 1'b0;
         pio_we_r   <= 1'b0;
         pio_idx_r  <= '0;
         pio_data_r <= '0;
         irq_r      <= 1'b0;
         err_r      <= 1'b0;
      end else if (chan_reset) begin
         state    <= S_IDLE;
         req_r    <= 1'b0;
         armed    <= 1'b0;
         word_idx <= '0;
         pio_we_r <= 1'b0;
         irq_r    <= 1'b0;
         err_r    <= 1'b0;
      end else begin
         pio_we_r <= 1'b0;
         irq_r    <= 1'b0;
         err_r    <= 1'b0;
         case (state)
            S_IDLE: begin
               word_idx <= '0;
               if (start_addr_we) cur_addr <= start_addr;
               if (run_ok) state <= S_FETCH;
            end
            S_FETCH: begin
               if (!req_r) begin
                  if (!freeze) req_r <= 1'b1;
               end else if (mem_ack) begin
                  req_r <= 1'b0;
                  case (word_idx)
                     IDXW'(0): next_ptr <= mem_rdata[AW-1:0];
                     IDXW'(1): {len_r, cmd_raw} <= mem_rdata;
                     IDXW'(2): buf_r <= mem_rdata[AW-1:0];
                     default: begin
                        pio_we_r   <= 1'b1;
                        pio_idx_r  <= pio_off[3:0];
                        pio_data_r <= mem_rdata;
                     end
                  endcase
                  if (last_word) begin
                     if (cmd_bad) begin
                        err_r <= 1'b1;
                        state <= S_HALT;
                     end else if (cmd.op != OP_NONE) begin
                        state <= S_XSTART;
                     end else begin
                        state <= cmd.wend ? S_EWAIT : S_DONE;
                     end
                  end else begin
                     word_idx <= word_idx + 1'b1;
                  end
               end
            end
            S_XSTART: if (!freeze) state <= S_XWAIT;
            S_XWAIT: begin
               if (xfer_done) begin
                  if (xfer_err) begin
                     err_r <= 1'b1;
                     state <= S_HALT;
                  end else begin
                     state <= cmd.wend ? S_EWAIT : S_DONE;
                  end
               end
            end
            S_EWAIT: if (periph_end) state <= S_DONE;
            S_DONE: begin
               irq_r <= cmd.irq;
               if (cmd.chain) cur_addr <= next_ptr;
               else           armed    <= 1'b0;
               state <= S_IDLE;
            end
            S_HALT: state <= S_HALT;
            default: state <= S_IDLE;
         endcase
         if (sema_we) armed <= 1'b1;
      end
   end

   assign mem_req    = req_r;
   assign mem_addr   = cur_addr + (AW'(word_idx) << 2);
   assign pio_we     = pio_we_r;
   assign pio_idx    = pio_idx_r;
   assign pio_data   = pio_data_r;
   assign xfer_start = (state == S_XSTART) && !freeze;
   assign xfer_op    = cmd_raw[1:0];
   assign xfer_addr  = buf_r;
   assign xfer_len   = len_r;
   assign irq_pulse  = irq_r;
   assign err_pulse  = err_r;
   assign halted     = (state == S_HALT);
   assign busy       = ((state != S_IDLE) && (state != S_HALT)) ||
                       ((state == S_IDLE) && armed && (sema_level != '0));

   // R10: a frozen channel raises no new memory request
   a_r10_freeze_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !mem_req) |=> !mem_req);

   // R11: a halted channel stays halted until reset and issues nothing
   a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !chan_reset) |=> halted);
   a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_req && !xfer_start && !irq_pulse));

   // R8: completion pulse is a single cycle
   a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   // R4: inline register index below decoded word count
   a_r4_pio_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      pio_we |-> (pio_idx < cmd.npio));

   // R5/R3: data phase never overlaps a read and respects the byte limit
   a_r5_start_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !mem_req);
   a_r3_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (32'(xfer_len) <= 32'(MAX_LEN)));

   // R9: while holding for the end signal no completion is given
   a_r9_hold_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_EWAIT && !periph_end) |=> !irq_pulse);

   // R12: abort leaves the channel idle
   a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset |=> (!busy && !halted && !mem_req));
endmodule

// File: tb/cmd_chain_seq_tb.sv
module cmd_chain_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_reset = 1'b0, freeze = 1'b0;
   logic        start_addr_we = 1'b0;
   logic [31:0] start_addr = '0;
   logic        sema_we = 1'b0;
   logic [7:0]  sema_val = '0;
   logic [7:0]  sema_level;
   logic        mem_req, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic        pio_we;
   logic [3:0]  pio_idx;
   logic [31:0] pio_data;
   logic        xfer_start, xfer_done = 1'b0, xfer_err = 1'b0;
   logic [1:0]  xfer_op;
   logic [31:0] xfer_addr;
   logic [15:0] xfer_len;
   logic        periph_end = 1'b0;
   logic        irq_pulse, err_pulse, busy, halted;

   always #5 clk = ~clk;

   cmd_chain_seq u_dut (
      .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .freeze(freeze),
      .start_addr_we(start_addr_we), .start_addr(start_addr),
      .sema_we(sema_we), .sema_val(sema_val), .sema_level(sema_level),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
      .xfer_start(xfer_start), .xfer_op(xfer_op), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
      .xfer_done(xfer_done), .xfer_err(xfer_err), .periph_end(periph_end),
      .irq_pulse(irq_pulse), .err_pulse(err_pulse), .busy(busy), .halted(halted)
   );

   int total = 0, bad = 0;
   logic [31:0] mem [0:63];
   int n_pio, n_irq, n_err, n_x, n_req;
   logic [3:0]  p_idx [0:15];
   logic [31:0] p_dat [0:15];
   logic [1:0]  x_op  [0:7];
   logic [31:0] x_adr [0:7];
   logic [15:0] x_len [0:7];
   int  mv_cnt = 0;
   logic inj_err = 1'b0, req_prev = 1'b0;

   // memory model: acknowledge a held request one half cycle later
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   = 1'b1;
         mem_rdata = mem[mem_addr[7:2]];
      end else begin
         mem_ack = 1'b0;
      end
   end

   // data mover stub: done two cycles after start
   always @(negedge clk) begin
      if (xfer_start) begin
         if (n_x < 8) begin
            x_op[n_x] = xfer_op; x_adr[n_x] = xfer_addr; x_len[n_x] = xfer_len;
         end
         n_x++;
         mv_cnt = 2; xfer_done = 1'b0; xfer_err = 1'b0;
      end else if (mv_cnt > 0) begin
         mv_cnt--;
         if (mv_cnt == 0) begin xfer_done = 1'b1; xfer_err = inj_err; end
      end else begin
         xfer_done = 1'b0; xfer_err = 1'b0;
      end
   end

   // output monitor
   always @(negedge clk) begin
      if (pio_we) begin
         if (n_pio < 16) begin p_idx[n_pio] = pio_idx; p_dat[n_pio] = pio_data; end
         n_pio++;
      end
      if (irq_pulse) n_irq++;
      if (err_pulse) n_err++;
      if (mem_req && !req_prev) n_req++;
      req_prev = mem_req;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr_log();
      n_pio = 0; n_irq = 0; n_err = 0; n_x = 0; n_req = 0;
   endtask

   function automatic logic [15:0] mk_cmd(input int op, input bit ch, input bit irq,
                                          input bit dec, input bit wend, input int npio);
      return 16'(op & 3) | (16'(ch) << 2) | (16'(irq) << 3) | (16'(dec) << 6) |
             (16'(wend) << 7) | (16'(npio & 15) << 12);
   endfunction

   task automatic put_desc(input int w, input logic [31:0] nxt, input logic [15:0] cmd,
                           input logic [15:0] len, input logic [31:0] bufa,
                           input int npio, input logic [31:0] pbase);
      mem[w] = nxt; mem[w+1] = {len, cmd}; mem[w+2] = bufa;
      for (int k = 0; k < npio; k++) mem[w+3+k] = pbase + 32'(k);
   endtask

   task automatic sema_write(input int v);
      @(negedge clk) sema_we = 1'b1; sema_val = 8'(v);
      @(negedge clk) sema_we = 1'b0;
   endtask

   task automatic kick(input logic [31:0] a, input int v);
      @(negedge clk) start_addr_we = 1'b1; start_addr = a;
      @(negedge clk) start_addr_we = 1'b0;
      sema_write(v);
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 5000) begin @(negedge clk); n++; end
      if (n >= 5000) chk("watchdog idle", 0, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_halt();
      int n = 0;
      while (!halted && n < 5000) begin @(negedge clk); n++; end
      if (n >= 5000) chk("watchdog halt", 0, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_xfer(input int cnt);
      int n = 0;
      while (n_x < cnt && n < 5000) begin @(negedge clk); n++; end
      if (n >= 5000) chk("watchdog xfer", 0, 1);
   endtask

   task automatic pulse_reset();
      @(negedge clk) chan_reset = 1'b1;
      @(negedge clk) chan_reset = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      clr_log();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 halted", halted, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 sema", sema_level, 0);
      chk("R1 pulses", {irq_pulse, err_pulse}, 0);

      // R2: a semaphore of zero fetches nothing
      clr_log();
      kick(0, 0);
      repeat (10) @(negedge clk);
      chk("R2 no fetch at zero", n_req, 0);

      // R3/R4/R8 sweep of every inline word count, no data phase
      for (int n = 0; n < 16; n++) begin
         int mism = 0;
         put_desc(0, 32'h0, mk_cmd(0, 0, 1, 1, 0, n), 16'h0, 32'h0, n, 32'hA000_0000 + 32'(n*16));
         clr_log();
         kick(0, 1);
         wait_idle();
         chk($sformatf("R4 pio count n=%0d", n), n_pio, n);
         for (int k = 0; k < n; k++)
            if (p_idx[k] != 4'(k) || p_dat[k] != 32'hA000_0000 + 32'(n*16 + k)) mism++;
         chk($sformatf("R3 pio order/data n=%0d", n), mism, 0);
         chk($sformatf("R8 irq n=%0d", n), n_irq, 1);
         chk($sformatf("R7 sema n=%0d", n), sema_level, 0);
         chk($sformatf("R5 no xfer op0 n=%0d", n), n_x, 0);
      end

      // R5/R6/R8: two-descriptor chain, write then read at max length
      put_desc(20, 32'd96, mk_cmd(1, 1, 0, 0, 0, 1), 16'd100, 32'h1000, 1, 32'h5555_0000);
      put_desc(24, 32'd0, mk_cmd(2, 0, 1, 1, 0, 0), 16'hFF00, 32'h2000, 0, 0);
      clr_log();
      kick(80, 1);
      wait_idle();
      chk("R5 chain xfer count", n_x, 2);
      chk("R5 first op", x_op[0], 1);
      chk("R5 first addr", x_adr[0], 32'h1000);
      chk("R5 first len", x_len[0], 100);
      chk("R5 second op", x_op[1], 2);
      chk("R5 second addr", x_adr[1], 32'h2000);
      chk("R3 len FF00 accepted", x_len[1], 16'hFF00);
      chk("R8 irq only last", n_irq, 1);
      chk("R4 pio before data", n_pio, 1);
      chk("R11 no error", n_err, 0);

      // R6/R7 ring of two, runs until semaphore empty, then resumes
      put_desc(28, 32'd128, mk_cmd(1, 1, 1, 1, 0, 0), 16'd8, 32'h3000, 0, 0);
      put_desc(32, 32'd112, mk_cmd(1, 1, 1, 1, 0, 0), 16'd8, 32'h4000, 0, 0);
      clr_log();
      kick(112, 3);
      wait_idle();
      chk("R7 ring xfers", n_x, 3);
      chk("R6 ring addr0", x_adr[0], 32'h3000);
      chk("R6 ring addr1", x_adr[1], 32'h4000);
      chk("R6 ring addr2", x_adr[2], 32'h3000);
      chk("R8 ring irqs", n_irq, 3);
      chk("R7 ring sema zero", sema_level, 0);
      chk("R7 ring stopped", busy, 0);
      sema_write(1);
      wait_idle();
      chk("R6 resume count", n_x, 4);
      chk("R6 resume addr", x_adr[3], 32'h4000);

      // R9 hold completion for peripheral end
      put_desc(36, 32'd0, mk_cmd(2, 0, 1, 1, 1, 0), 16'd4, 32'h5000, 0, 0);
      clr_log();
      kick(144, 1);
      wait_xfer(1);
      repeat (10) @(negedge clk);
      chk("R9 no irq before end", n_irq, 0);
      chk("R9 still busy", busy, 1);
      chk("R9 sema held", sema_level, 1);
      @(negedge clk) periph_end = 1'b1;
      @(negedge clk) periph_end = 1'b0;
      wait_idle();
      chk("R9 irq after end", n_irq, 1);
      chk("R9 sema after end", sema_level, 0);

      // R10 freeze
      put_desc(40, 32'd0, mk_cmd(0, 0, 1, 1, 0, 2), 16'd0, 32'h0, 2, 32'hBEEF_0000);
      clr_log();
      freeze = 1'b1;
      kick(160, 1);
      repeat (20) @(negedge clk);
      chk("R10 no req frozen", n_req, 0);
      chk("R10 no irq frozen", n_irq, 0);
      chk("R10 sema kept", sema_level, 1);
      freeze = 1'b0;
      wait_idle();
      chk("R10 resumed irq", n_irq, 1);
      chk("R10 resumed pio", n_pio, 2);

      // R11 data mover error
      put_desc(48, 32'd0, mk_cmd(1, 0, 1, 1, 0, 0), 16'd16, 32'h6000, 0, 0);
      clr_log();
      inj_err = 1'b1;
      kick(192, 1);
      wait_halt();
      inj_err = 1'b0;
      chk("R11 err pulse", n_err, 1);
      chk("R11 halted", halted, 1);
      chk("R11 no irq", n_irq, 0);
      chk("R11 no dec", sema_level, 1);
      pulse_reset();
      @(negedge clk);
      chk("R12 halt cleared", halted, 0);
      chk("R12 sema cleared", sema_level, 0);

      // R11 operation code 3
      put_desc(52, 32'd0, mk_cmd(3, 0, 1, 1, 0, 0), 16'd4, 32'h7000, 0, 0);
      clr_log();
      kick(208, 1);
      wait_halt();
      chk("R11 op3 err", n_err, 1);
      chk("R11 op3 no xfer", n_x, 0);
      pulse_reset();

      // R11 byte count above limit
      put_desc(56, 32'd0, mk_cmd(1, 0, 1, 1, 0, 0), 16'hFF01, 32'h8000, 0, 0);
      clr_log();
      kick(224, 1);
      wait_halt();
      chk("R11 len err", n_err, 1);
      chk("R11 len no xfer", n_x, 0);
      pulse_reset();

      // R12 abort while holding for end
      put_desc(60, 32'd0, mk_cmd(2, 0, 1, 1, 1, 0), 16'd4, 32'h9000, 0, 0);
      clr_log();
      kick(240, 1);
      wait_xfer(1);
      repeat (5) @(negedge clk);
      pulse_reset();
      @(negedge clk);
      chk("R12 abort idle", busy, 0);
      chk("R12 abort sema", sema_level, 0);
      @(negedge clk) periph_end = 1'b1;
      @(negedge clk) periph_end = 1'b0;
      repeat (10) @(negedge clk);
      chk("R12 no irq after abort", n_irq, 0);
      chk("R12 no fetch after abort", mem_req, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule